// File: doc/BRIEF.md
# Forwarding Engine Dispatch Controller

This block is the master sequencer of a packet forwarding engine. It requests a packet from the ingress queue and sits idle until the arbiter grants it one. It then starts header parsing. From the parsed EtherType, IP protocol and IP destination it picks a processing agent: L3 routing, an ICMP responder for traffic addressed to the router itself, ARP handling, or plain L2 forwarding. Each agent is driven with a one-cycle request and answers with a done strobe and a fail flag. Any failure in the L3, ARP or ICMP agent sends the packet down the default L2 path.

After an agent succeeds, the controller runs a statistics step and then a policing step. The policing step may mark the packet for drop. The result, with the packet length and source port captured at grant time, is then handed to the packet buffer. Two packet memory banks are used in turn, and the bank in use flips at each handoff. If the grant is lost or soft reset is raised, the packet is abandoned at once.

Top module: `pkt_dispatch_ctrl`

## Requirements
- R1: After reset, `fetch_req` is 1. `parse_req`, `agent_req`, `stats_req`, `police_req` and `out_valid` are 0, and `out_bank` is 0.
- R2: The controller stays idle (`fetch_req`=1) until `proc_gnt` is 1. In the cycle after the grant is sampled, `parse_req` is high for exactly one cycle and `fetch_req` drops.
- R3: When `parse_done` is seen with EtherType 0x0800, and the packet is not an own-address ICMP packet, the next cycle pulses `agent_req` bit 1 (L3). An IPv4 packet with protocol 1 to a foreign address also takes this path.
- R4: EtherType 0x0806 pulses `agent_req` bit 2 (ARP).
- R5: EtherType 0x0800 with IP protocol 1, and an IP destination equal to any of the `own_ip` words, pulses `agent_req` bit 3 (ICMP).
- R6: Any other EtherType pulses `agent_req` bit 0 (L2).
- R7: If the active L3, ARP or ICMP agent reports done with `agent_fail` set, `agent_req` bit 0 pulses in the next cycle, and the handoff reports `out_path`=0. A failure flag on the L2 agent is ignored.
- R8: A successful agent done is followed next cycle by a one-cycle `stats_req`. `stats_done` is followed by a one-cycle `police_req`. `police_done` is followed by a one-cycle `out_valid`, with `out_drop` equal to `police_drop` and `out_path` equal to the agent that completed (0 L2, 1 L3, 2 ARP, 3 ICMP).
- R9: At `out_valid`, `out_len` and `out_src` equal the `pkt_len` and `pkt_src` present when the grant was taken. `out_bank` starts at 0 and alternates with each handoff.
- R10: Low `proc_gnt` or high `soft_rst` in any busy state returns the controller to idle in the next cycle. This takes precedence over a done strobe in the same cycle. No `out_valid` follows, and the bank does not alternate.
- R11: `agent_req` never has more than one bit set, and a successful agent receives only a single-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Abandon the current packet |
| proc_gnt | input | 1 | Processing grant from the arbiter, held while busy |
| fetch_req | output | 1 | Request for a new packet (idle) |
| pkt_len | input | LEN_W | Packet length, sampled with the grant |
| pkt_src | input | SRC_W | Source port, sampled with the grant |
| parse_req | output | 1 | Start header parsing (pulse) |
| parse_done | input | 1 | Parsed header fields are valid |
| eth_type | input | 16 | Parsed EtherType |
| ip_proto | input | 8 | Parsed IP protocol |
| ip_dst | input | 32 | Parsed IP destination |
| own_ip | input | N_OWN_IP*32 | Router's own addresses, one 32-bit word per port |
| agent_req | output | 4 | One-hot agent request pulse (0 L2, 1 L3, 2 ARP, 3 ICMP) |
| agent_done | input | 4 | Agent done strobes, same bit order |
| agent_fail | input | 4 | Agent failure flags, valid with done |
| stats_req | output | 1 | Start statistics update (pulse) |
| stats_done | input | 1 | Statistics update finished |
| police_req | output | 1 | Start policing (pulse) |
| police_done | input | 1 | Policing finished |
| police_drop | input | 1 | Policing verdict: drop, valid with done |
| out_valid | output | 1 | Handoff to packet buffer (pulse) |
| out_drop | output | 1 | Packet to be dropped |
| out_path | output | 2 | Agent that completed the packet |
| out_bank | output | 1 | Packet memory bank holding the packet |
| out_len | output | LEN_W | Length of the handed-off packet |
| out_src | output | SRC_W | Source port of the handed-off packet |

## Verification
An abort can arrive in the same cycle as a completion strobe: the grant is withdrawn while `police_done` is high, or soft reset is raised together with an agent done. The bench drives these pairs on the same clock edge and requires an idle return with no handoff. It then checks that the next completed packet still reports the bank predicted from completed packets only. A scoreboard queue holds the path, drop flag, length, source port and bank expected for each packet. These are compared against every `out_valid`, and a handoff that arrives with an empty queue is counted as a mismatch.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    AG_L2   = 2'd0,
    AG_L3   = 2'd1,
    AG_ARP  = 2'd2,
    AG_ICMP = 2'd3
  } agent_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PARSE  = 3'd1,
    ST_AGENT  = 3'd2,
    ST_STATS  = 3'd3,
    ST_POLICE = 3'd4
  } state_e;

  localparam int          N_AGENT    = 4;
  localparam int          N_BANK     = 2;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [7:0]  PROTO_ICMP = 8'd1;
endpackage

// File: rtl/pdc_classify.sv
module pdc_classify
  import pdc_pkg::*;
#(
  parameter int N_OWN_IP = 4
) (
  input  logic [15:0]            eth_type,
  input  logic [7:0]             ip_proto,
  input  logic [31:0]            ip_dst,
  input  logic [N_OWN_IP*32-1:0] own_ip,
  output agent_e                 pick
);
  logic [N_OWN_IP-1:0] hit_vec;
  logic                is_ipv4;
  logic                is_arp;
  logic                own_icmp;

  for (genvar g = 0; g < N_OWN_IP; g++) begin : g_addr_cmp
    assign hit_vec[g] = (ip_dst == own_ip[g*32 +: 32]);
  end

  assign is_ipv4  = (eth_type == ETYPE_IPV4);
  assign is_arp   = (eth_type == ETYPE_ARP);
  assign own_icmp = is_ipv4 && (ip_proto == PROTO_ICMP) && (|hit_vec);

  always_comb begin
    if (own_icmp)      pick = AG_ICMP;
    else if (is_ipv4)  pick = AG_L3;
    else if (is_arp)   pick = AG_ARP;
    else               pick = AG_L2;
  end

  // R5: ICMP is only chosen for IPv4 traffic
  always_comb begin
    if (pick == AG_ICMP) begin
      p_icmp_ipv4_r5: assert (eth_type == ETYPE_IPV4);
    end
  end
endmodule

// File: rtl/pdc_bank_store.sv
module pdc_bank_store
  import pdc_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             hand_en,
  input  logic [LEN_W-1:0] in_len,
  input  logic [SRC_W-1:0] in_src,
  output logic             out_bank,
  output logic [LEN_W-1:0] out_len,
  output logic [SRC_W-1:0] out_src
);
  logic             wr_bank;
  logic [LEN_W-1:0] len_q [N_BANK];
  logic [SRC_W-1:0] src_q [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[b] <= '0;
        src_q[b] <= '0;
      end else if (cap_en && (wr_bank == b[0])) begin
        len_q[b] <= in_len;
        src_q[b] <= in_src;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank  <= 1'b0;
      out_bank <= 1'b0;
      out_len  <= '0;
      out_src  <= '0;
    end else if (hand_en) begin
      wr_bank  <= ~wr_bank;
      out_bank <= wr_bank;
      out_len  <= len_q[wr_bank];
      out_src  <= src_q[wr_bank];
    end
  end

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hand_en |=> $stable(wr_bank));
  p_bank_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hand_en |=> (wr_bank != out_bank) || !hand_en);
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               proc_gnt,
  input  logic               parse_done,
  input  agent_e             agent_pick,
  input  logic [N_AGENT-1:0] agent_done,
  input  logic [N_AGENT-1:0] agent_fail,
  input  logic               stats_done,
  input  logic               police_done,
  input  logic               police_drop,
  output logic               fetch_req,
  output logic               parse_req,
  output logic [N_AGENT-1:0] agent_req,
  output logic               stats_req,
  output logic               police_req,
  output logic               cap_en,
  output logic               hand_en,
  output logic               out_valid,
  output logic               out_drop,
  output agent_e             out_path
);
  state_e state_q, state_d;
  agent_e sel_q, sel_d;
  logic   fire_parse, fire_agent, fire_stats, fire_police;
  logic   abort;
  logic   cur_done, cur_fail;

  assign abort    = soft_rst || !proc_gnt;
  assign cur_done = agent_done[sel_q];
  assign cur_fail = agent_fail[sel_q] && (sel_q != AG_L2);

  always_comb begin
    state_d     = state_q;
    sel_d       = sel_q;
    fire_parse  = 1'b0;
    fire_agent  = 1'b0;
    fire_stats  = 1'b0;
    fire_police = 1'b0;
    cap_en      = 1'b0;
    hand_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (proc_gnt && !soft_rst) begin
          state_d    = ST_PARSE;
          fire_parse = 1'b1;
          cap_en     = 1'b1;
        end
      end
      ST_PARSE: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (parse_done) begin
          state_d    = ST_AGENT;
          sel_d      = agent_pick;
          fire_agent = 1'b1;
        end
      end
      ST_AGENT: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (cur_done) begin
          if (cur_fail) begin
            sel_d      = AG_L2;
            fire_agent = 1'b1;
          end else begin
            state_d    = ST_STATS;
            fire_stats = 1'b1;
          end
        end
      end
      ST_STATS: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (stats_done) begin
          state_d     = ST_POLICE;
          fire_police = 1'b1;
        end
      end
      ST_POLICE: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (police_done) begin
          state_d = ST_IDLE;
          hand_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sel_q      <= AG_L2;
      parse_req  <= 1'b0;
      agent_req  <= '0;
      stats_req  <= 1'b0;
      police_req <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      parse_req  <= fire_parse;
      agent_req  <= fire_agent ? (N_AGENT'(1) << sel_d) : '0;
      stats_req  <= fire_stats;
      police_req <= fire_police;
      out_valid  <= hand_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_drop <= 1'b0;
      out_path <= AG_L2;
    end else if (hand_en) begin
      out_drop <= police_drop;
      out_path <= sel_q;
    end
  end

  assign fetch_req = (state_q == ST_IDLE);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && abort) |=> (fetch_req && !out_valid));
  p_agent_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(agent_req));
  p_fallback_l2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AGENT && !abort && cur_done && cur_fail) |=> (agent_req == 4'b0001));
  p_parse_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    parse_req |=> !parse_req);
  p_stats_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stats_req |=> !stats_req);
  p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLICE && !abort && police_done) |=> (out_valid && out_drop == $past(police_drop)));
endmodule

// File: rtl/pkt_dispatch_ctrl.sv
module pkt_dispatch_ctrl
  import pdc_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int SRC_W    = 2,
  parameter int N_OWN_IP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   proc_gnt,
  output logic                   fetch_req,
  input  logic [LEN_W-1:0]       pkt_len,
  input  logic [SRC_W-1:0]       pkt_src,
  output logic                   parse_req,
  input  logic                   parse_done,
  input  logic [15:0]            eth_type,
  input  logic [7:0]             ip_proto,
  input  logic [31:0]            ip_dst,
  input  logic [N_OWN_IP*32-1:0] own_ip,
  output logic [3:0]             agent_req,
  input  logic [3:0]             agent_done,
  input  logic [3:0]             agent_fail,
  output logic                   stats_req,
  input  logic                   stats_done,
  output logic                   police_req,
  input  logic                   police_done,
  input  logic                   police_drop,
  output logic                   out_valid,
  output logic                   out_drop,
  output logic [1:0]             out_path,
  output logic                   out_bank,
  output logic [LEN_W-1:0]       out_len,
  output logic [SRC_W-1:0]       out_src
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  agent_e     pick;
  agent_e     path_e;
  logic       cap_en, hand_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pdc_classify #(.N_OWN_IP(N_OWN_IP)) u_classify (
    .eth_type (eth_type),
    .ip_proto (ip_proto),
    .ip_dst   (ip_dst),
    .own_ip   (own_ip),
    .pick     (pick)
  );

  pdc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .soft_rst    (soft_rst),
    .proc_gnt    (proc_gnt),
    .parse_done  (parse_done),
    .agent_pick  (pick),
    .agent_done  (agent_done),
    .agent_fail  (agent_fail),
    .stats_done  (stats_done),
    .police_done (police_done),
    .police_drop (police_drop),
    .fetch_req   (fetch_req),
    .parse_req   (parse_req),
    .agent_req   (agent_req),
    .stats_req   (stats_req),
    .police_req  (police_req),
    .cap_en      (cap_en),
    .hand_en     (hand_en),
    .out_valid   (out_valid),
    .out_drop    (out_drop),
    .out_path    (path_e)
  );
  assign out_path = path_e;

  pdc_bank_store #(.LEN_W(LEN_W), .SRC_W(SRC_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (cap_en),
    .hand_en  (hand_en),
    .in_len   (pkt_len),
    .in_src   (pkt_src),
    .out_bank (out_bank),
    .out_len  (out_len),
    .out_src  (out_src)
  );
endmodule

// File: tb/pkt_dispatch_ctrl_tb_top.sv
module pkt_dispatch_ctrl_tb_top;
  localparam int LEN_W = 11;
  localparam int SRC_W = 2;
  localparam int NIP   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic soft_rst, proc_gnt, parse_done, stats_done, police_done, police_drop;
  logic fetch_req, parse_req, stats_req, police_req, out_valid, out_drop, out_bank;
  logic [LEN_W-1:0] pkt_len, out_len;
  logic [SRC_W-1:0] pkt_src, out_src;
  logic [15:0] eth_type;
  logic [7:0]  ip_proto;
  logic [31:0] ip_dst;
  logic [NIP*32-1:0] own_ip;
  logic [3:0] agent_req, agent_done, agent_fail;
  logic [1:0] out_path;

  always #5 clk = ~clk;

  pkt_dispatch_ctrl #(.LEN_W(LEN_W), .SRC_W(SRC_W), .N_OWN_IP(NIP)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .proc_gnt(proc_gnt),
    .fetch_req(fetch_req), .pkt_len(pkt_len), .pkt_src(pkt_src),
    .parse_req(parse_req), .parse_done(parse_done), .eth_type(eth_type),
    .ip_proto(ip_proto), .ip_dst(ip_dst), .own_ip(own_ip),
    .agent_req(agent_req), .agent_done(agent_done), .agent_fail(agent_fail),
    .stats_req(stats_req), .stats_done(stats_done), .police_req(police_req),
    .police_done(police_done), .police_drop(police_drop), .out_valid(out_valid),
    .out_drop(out_drop), .out_path(out_path), .out_bank(out_bank),
    .out_len(out_len), .out_src(out_src)
  );

  typedef struct packed {
    logic [1:0]       path;
    logic             drop;
    logic [LEN_W-1:0] len;
    logic [SRC_W-1:0] src;
    logic             bank;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic exp_bank = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: compare each handoff with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_path == e.path, "R7/R8", "out_path", out_path, e.path);
        chk(out_drop == e.drop, "R8", "out_drop", out_drop, e.drop);
        chk(out_len == e.len, "R9", "out_len", out_len, e.len);
        chk(out_src == e.src, "R9", "out_src", out_src, e.src);
        chk(out_bank == e.bank, "R9", "out_bank", out_bank, e.bank);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic grant_and_parse(input logic [LEN_W-1:0] len, input logic [SRC_W-1:0] src,
                                 input logic [15:0] et, input logic [7:0] pr,
                                 input logic [31:0] dst, input logic [1:0] first,
                                 input string req);
    pkt_len = len; pkt_src = src; proc_gnt = 1'b1;
    tick();
    chk(parse_req == 1'b1 && fetch_req == 1'b0, "R2", "parse_req after grant", parse_req, 1);
    eth_type = et; ip_proto = pr; ip_dst = dst; parse_done = 1'b1;
    tick();
    parse_done = 1'b0;
    chk(parse_req == 1'b0, "R2", "parse_req one cycle", parse_req, 0);
    chk(agent_req == (4'b1 << first), req, "agent_req select", agent_req, 4'b1 << first);
  endtask

  task automatic run_pkt(input logic [LEN_W-1:0] len, input logic [SRC_W-1:0] src,
                         input logic [15:0] et, input logic [7:0] pr,
                         input logic [31:0] dst, input logic [1:0] first,
                         input logic fail, input logic drop, input string req);
    exp_t e;
    logic [1:0] fin;
    fin = (fail && first != 2'd0) ? 2'd0 : first;
    e.path = fin; e.drop = drop; e.len = len; e.src = src; e.bank = exp_bank;
    exp_q.push_back(e);
    exp_bank = ~exp_bank;
    grant_and_parse(len, src, et, pr, dst, first, req);
    tick();
    chk(agent_req == 4'b0, "R11", "agent_req single cycle", agent_req, 0);
    agent_done = 4'b1 << first; agent_fail = fail ? (4'b1 << first) : 4'b0;
    tick();
    agent_done = 4'b0; agent_fail = 4'b0;
    if (fail && first != 2'd0) begin
      chk(agent_req == 4'b0001, "R7", "fallback L2 req", agent_req, 1);
      agent_done = 4'b0001;
      tick();
      agent_done = 4'b0;
    end
    chk(stats_req == 1'b1, "R8", "stats_req", stats_req, 1);
    stats_done = 1'b1;
    tick();
    stats_done = 1'b0;
    chk(police_req == 1'b1 && stats_req == 1'b0, "R8", "police_req", police_req, 1);
    police_done = 1'b1; police_drop = drop;
    tick();
    police_done = 1'b0; police_drop = 1'b0; proc_gnt = 1'b0;
    chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
    tick();
    chk(out_valid == 1'b0 && fetch_req == 1'b1, "R8", "out_valid pulse", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; proc_gnt = 1'b0; parse_done = 1'b0;
    stats_done = 1'b0; police_done = 1'b0; police_drop = 1'b0;
    pkt_len = '0; pkt_src = '0; eth_type = '0; ip_proto = '0; ip_dst = '0;
    agent_done = '0; agent_fail = '0;
    own_ip = {32'h0A000104, 32'h0A000103, 32'h0A000102, 32'h0A000101};
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk(fetch_req == 1'b1, "R1", "fetch_req", fetch_req, 1);
    chk(parse_req == 0 && stats_req == 0 && police_req == 0, "R1", "req idle", parse_req, 0);
    chk(agent_req == 4'b0 && out_valid == 1'b0, "R1", "agent/out idle", agent_req, 0);
    chk(out_bank == 1'b0, "R1", "out_bank", out_bank, 0);
    // R2 idle without grant
    repeat (3) tick();
    chk(fetch_req == 1'b1 && parse_req == 1'b0, "R2", "idle w/o grant", parse_req, 0);

    run_pkt(11'd64,   2'd1, 16'h0800, 8'd6, 32'hC0A80001, 2'd1, 0, 0, "R3");
    run_pkt(11'd60,   2'd2, 16'h0806, 8'd0, 32'h0,        2'd2, 0, 0, "R4");
    run_pkt(11'd98,   2'd3, 16'h0800, 8'd1, 32'h0A000103, 2'd3, 0, 0, "R5");
    run_pkt(11'd98,   2'd0, 16'h0800, 8'd1, 32'h0A000109, 2'd1, 0, 1, "R3");
    run_pkt(11'd1500, 2'd1, 16'h86DD, 8'd1, 32'h0A000101, 2'd0, 0, 0, "R6");
    run_pkt(11'd128,  2'd2, 16'h0800, 8'd17, 32'h01020304, 2'd1, 1, 0, "R7");
    run_pkt(11'd64,   2'd3, 16'h0806, 8'd0, 32'h0,        2'd2, 1, 1, "R7");
    run_pkt(11'd74,   2'd0, 16'h0800, 8'd1, 32'h0A000104, 2'd3, 1, 0, "R7");
    run_pkt(11'd77,   2'd1, 16'h1234, 8'd0, 32'h0,        2'd0, 1, 0, "R7");

    // R10 soft reset during parse wait
    pkt_len = 11'd300; proc_gnt = 1'b1;
    tick();
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0; proc_gnt = 1'b0;
    chk(fetch_req == 1'b1 && agent_req == 4'b0, "R10", "soft_rst to idle", fetch_req, 1);
    // R10 soft reset together with agent done
    grant_and_parse(11'd400, 2'd2, 16'h0800, 8'd6, 32'h1, 2'd1, "R3");
    soft_rst = 1'b1; agent_done = 4'b0010;
    tick();
    soft_rst = 1'b0; agent_done = 4'b0; proc_gnt = 1'b0;
    chk(fetch_req == 1'b1 && stats_req == 1'b0, "R10", "abort beats agent done", stats_req, 0);
    // R10 grant lost together with police_done
    grant_and_parse(11'd500, 2'd3, 16'h0806, 8'd0, 32'h0, 2'd2, "R4");
    agent_done = 4'b0100;
    tick();
    agent_done = 4'b0; stats_done = 1'b1;
    tick();
    stats_done = 1'b0; police_done = 1'b1; proc_gnt = 1'b0;
    tick();
    police_done = 1'b0;
    chk(out_valid == 1'b0 && fetch_req == 1'b1, "R10", "no handoff on abort", out_valid, 0);
    repeat (3) tick();
    // bank must not have moved: next packet checks expected bank
    run_pkt(11'd66, 2'd2, 16'h0800, 8'd6, 32'h5, 2'd1, 0, 0, "R9");
    run_pkt(11'd67, 2'd3, 16'h0806, 8'd0, 32'h0, 2'd2, 0, 0, "R9");
    repeat (3) tick();
    chk(exp_q.size() == 0, "R8", "all handoffs seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule